// File: doc/BRIEF.md
# Instruction-Boundary Interrupt and Bus-Grant Sequencer

This block sits beside a processor's fetch unit and decides what happens each time an instruction retires. If the retiring instruction is marked interruptible, the block samples two external request levels. A bus request halts fetching and hands the memory bus to an external DMA master. A maskable interrupt request, honoured only while interrupt enable is set, issues a one-cycle command to load the program counter with the interrupt vector. At any other time the processor keeps fetching.

Both request lines are short windows driven by a display controller: the interrupt lasts 3,791 clocks and the bus request 114 clocks. Nothing is latched. If a window closes with no interruptible boundary inside it, that request is lost without trace. The block also presents the fixed program-counter value that the fetch unit uses after reset.

Top module: `irq_bus_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `vec_load_o`, `bus_ack_o` and `fetch_stall_o` are 0, and `reset_pc_o` is 16'h1000 at all times.
- R2: `vec_addr_o` carries 16'h1004 whenever `vec_load_o` is 1.
- R3: A boundary where `instr_done_i` and `instr_intr_i` are both 1 in cycle N, with `intr_req_i` = 1, `int_en_i` = 1, `bus_req_i` = 0 and no grant active, makes `vec_load_o` 1 in cycle N+1 only.
- R4: With `int_en_i` = 0 at a boundary, an interrupt request produces no vector load.
- R5: A cycle in which `instr_done_i` = 0, or in which `instr_intr_i` = 0, starts neither a vector load nor a bus grant.
- R6: A bus request at an interruptible boundary makes `bus_ack_o` and `fetch_stall_o` 1 from the next cycle, whatever the value of `int_en_i`.
- R7: Once granted, `bus_ack_o` and `fetch_stall_o` stay 1 while `bus_req_i` is 1. They fall in the cycle after `bus_req_i` is sampled at 0.
- R8: When both requests are present at the same boundary, the bus is granted and no vector load occurs. A still-present interrupt is then taken at the first interruptible boundary after release.
- R9: A request that drops before any interruptible boundary leaves no state behind. A later boundary with the request low produces no action.
- R10: While the bus is granted, instruction-complete strobes start no vector load, and `bus_ack_o` and `vec_load_o` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| intr_req_i | input | 1 | Maskable interrupt request level |
| bus_req_i | input | 1 | External bus request level |
| int_en_i | input | 1 | Interrupt-enable flag |
| instr_done_i | input | 1 | Instruction-complete strobe |
| instr_intr_i | input | 1 | Completing instruction is interruptible |
| vec_load_o | output | 1 | One-cycle command to load PC with vector |
| vec_addr_o | output | 16 | Interrupt vector address |
| fetch_stall_o | output | 1 | Fetch halted while bus is granted |
| bus_ack_o | output | 1 | Bus acknowledge to requester |
| reset_pc_o | output | 16 | Program-counter value after reset |

## Verification
The checker follows the cycle-to-cycle rules on every cycle. These are the one-cycle latency from an eligible boundary to a vector load or a grant, masking by the enable flag, holding and releasing the grant with the request level, and the exclusion between grant and vector load. What only the bench scenarios can show are the sequences that cross many cycles. One is a request window that passes by in full under non-interruptible instructions and is lost. Another is an interrupt that survives a bus grant and is taken at the first boundary after release. A sweep over every input combination at a boundary covers the arbitration table.

// File: rtl/irq_bus_seq_pkg.sv
package irq_bus_seq_pkg;
  localparam int unsigned ADDR_W = 16;

  typedef enum logic [0:0] {
    SEQ_RUN   = 1'b0,
    SEQ_GRANT = 1'b1
  } seq_state_e;
endpackage

// File: rtl/seq_boundary.sv
module seq_boundary (
  input  logic grant_i,
  input  logic instr_done_i,
  input  logic instr_intr_i,
  input  logic intr_req_i,
  input  logic bus_req_i,
  input  logic int_en_i,
  output logic take_bus_o,
  output logic take_int_o
);
  logic eligible;

  // requests only count at a retiring interruptible instruction, never during a grant
  assign eligible   = instr_done_i & instr_intr_i & ~grant_i;
  // bus request wins and ignores the enable flag
  assign take_bus_o = eligible & bus_req_i;
  assign take_int_o = eligible & ~bus_req_i & intr_req_i & int_en_i;
endmodule

// File: rtl/seq_grant_fsm.sv
module seq_grant_fsm
  import irq_bus_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_bus_i,
  input  logic bus_req_i,
  output logic grant_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_RUN:   if (take_bus_i) state_d = SEQ_GRANT;
      SEQ_GRANT: if (!bus_req_i) state_d = SEQ_RUN;
      default:   state_d = SEQ_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEQ_RUN;
    else         state_q <= state_d;
  end

  assign grant_o = (state_q == SEQ_GRANT);
endmodule

// File: rtl/seq_vector.sv
module seq_vector (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_int_i,
  output logic vec_load_o
);
  logic load_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) load_q <= 1'b0;
    else         load_q <= take_int_i;
  end

  assign vec_load_o = load_q;
endmodule

// File: rtl/irq_bus_seq.sv
module irq_bus_seq
  import irq_bus_seq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RESET_PC = 16'h1000,
  parameter logic [ADDR_W-1:0] INTR_VEC = 16'h1004
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              intr_req_i,
  input  logic              bus_req_i,
  input  logic              int_en_i,
  input  logic              instr_done_i,
  input  logic              instr_intr_i,
  output logic              vec_load_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic              fetch_stall_o,
  output logic              bus_ack_o,
  output logic [ADDR_W-1:0] reset_pc_o
);
  logic grant;
  logic take_bus;
  logic take_int;

  seq_boundary u_boundary (
    .grant_i      (grant),
    .instr_done_i (instr_done_i),
    .instr_intr_i (instr_intr_i),
    .intr_req_i   (intr_req_i),
    .bus_req_i    (bus_req_i),
    .int_en_i     (int_en_i),
    .take_bus_o   (take_bus),
    .take_int_o   (take_int)
  );

  seq_grant_fsm u_grant (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_bus_i (take_bus),
    .bus_req_i  (bus_req_i),
    .grant_o    (grant)
  );

  seq_vector u_vector (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_int_i (take_int),
    .vec_load_o (vec_load_o)
  );

  assign vec_addr_o    = INTR_VEC;
  assign reset_pc_o    = RESET_PC;
  assign bus_ack_o     = grant;
  assign fetch_stall_o = grant;
endmodule

// File: rtl/irq_bus_seq_chk.sv
module irq_bus_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        intr_req_i,
  input logic        bus_req_i,
  input logic        int_en_i,
  input logic        instr_done_i,
  input logic        instr_intr_i,
  input logic        vec_load_o,
  input logic [15:0] vec_addr_o,
  input logic        fetch_stall_o,
  input logic        bus_ack_o
);
  logic bnd;
  assign bnd = instr_done_i & instr_intr_i;

  p_vec_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_load_o |-> vec_addr_o == 16'h1004);

  p_take_int_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bnd && intr_req_i && int_en_i && !bus_req_i && !bus_ack_o) |=> vec_load_o);

  p_no_vec_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bnd && intr_req_i && int_en_i) |=> !vec_load_o);

  p_no_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_ack_o && !(bnd && bus_req_i)) |=> !bus_ack_o);

  p_grant_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_ack_o && bnd && bus_req_i) |=> (bus_ack_o && fetch_stall_o));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_ack_o && bus_req_i) |=> (bus_ack_o && fetch_stall_o));

  p_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_ack_o && !bus_req_i) |=> (!bus_ack_o && !fetch_stall_o));

  p_bus_first_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bnd && bus_req_i) |=> !vec_load_o);

  p_ack_blocks_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ack_o |=> !vec_load_o);

  p_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_ack_o && vec_load_o));
endmodule

bind irq_bus_seq irq_bus_seq_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .intr_req_i    (intr_req_i),
  .bus_req_i     (bus_req_i),
  .int_en_i      (int_en_i),
  .instr_done_i  (instr_done_i),
  .instr_intr_i  (instr_intr_i),
  .vec_load_o    (vec_load_o),
  .vec_addr_o    (vec_addr_o),
  .fetch_stall_o (fetch_stall_o),
  .bus_ack_o     (bus_ack_o)
);

// File: tb/irq_bus_seq_tb_top.sv
`timescale 1ns/1ps
module irq_bus_seq_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        intr_req_i = 1'b0, bus_req_i = 1'b0, int_en_i = 1'b0;
  logic        instr_done_i = 1'b0, instr_intr_i = 1'b0;
  logic        vec_load_o, fetch_stall_o, bus_ack_o;
  logic [15:0] vec_addr_o, reset_pc_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  irq_bus_seq dut_i (
    .clk_i, .rst_ni, .intr_req_i, .bus_req_i, .int_en_i,
    .instr_done_i, .instr_intr_i, .vec_load_o, .vec_addr_o,
    .fetch_stall_o, .bus_ack_o, .reset_pc_o
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // apply inputs just after a falling edge, return after the next falling edge
  task automatic step(logic d, logic i, logic ir, logic br, logic en);
    instr_done_i = d; instr_intr_i = i; intr_req_i = ir; bus_req_i = br; int_en_i = en;
    @(negedge clk_i);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i);
    // R1 in reset
    check("R1 ack", bus_ack_o, 0);
    check("R1 vec", vec_load_o, 0);
    check("R1 stall", fetch_stall_o, 0);
    check("R1 pc", reset_pc_o, 32'h1000);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after", {bus_ack_o, vec_load_o, fetch_stall_o}, 0);

    // sweep all boundary input combinations from the run state (R3 R4 R5 R6 R8)
    for (int c = 0; c < 32; c++) begin
      logic d, i, ir, br, en, elig, e_ack, e_vec;
      {d, i, ir, br, en} = c[4:0];
      elig  = d & i;
      e_ack = elig & br;
      e_vec = elig & ~br & ir & en;
      step(d, i, ir, br, en);
      check("R6 sweep ack", bus_ack_o, e_ack);
      check("R6 sweep stall", fetch_stall_o, e_ack);
      check("R3 sweep vec", vec_load_o, e_vec);
      if (e_vec) check("R2 addr", vec_addr_o, 32'h1004);
      idle(1);
      check("R3 one pulse", vec_load_o, 0);
      check("R7 released", bus_ack_o, 0);
    end

    // R7: grant held with strobes present, released one cycle after request drops
    step(1, 1, 0, 1, 0);
    check("R6 masked flag", bus_ack_o, 1);
    for (int k = 0; k < 20; k++) begin
      step(1, 1, 1, 1, 1);
      check("R7 hold", bus_ack_o, 1);
      check("R10 no vec", vec_load_o, 0);
    end
    step(1, 1, 1, 0, 1);
    check("R7 drop", bus_ack_o, 0);
    check("R7 stall drop", fetch_stall_o, 0);
    check("R10 strobe in last grant cycle", vec_load_o, 0);
    idle(1);

    // R8: both pending, bus first, interrupt after release
    step(1, 1, 1, 1, 1);
    check("R8 bus wins", bus_ack_o, 1);
    check("R8 no vec", vec_load_o, 0);
    for (int k = 0; k < 5; k++) step(0, 0, 1, 1, 1);
    step(0, 0, 1, 0, 1);
    check("R8 released", bus_ack_o, 0);
    step(1, 0, 1, 0, 1);
    check("R8 noninterruptible no vec", vec_load_o, 0);
    step(1, 1, 1, 0, 1);
    check("R8 interrupt taken", vec_load_o, 1);
    idle(2);

    // R9: bus window of 114 cycles under non-interruptible instructions is lost
    for (int k = 0; k < 114; k++) begin
      step(1, 0, 0, 1, 1);
      if (bus_ack_o !== 1'b0) check("R5 bus miss", bus_ack_o, 0);
    end
    step(1, 1, 0, 0, 1);
    check("R9 bus window lost", bus_ack_o, 0);
    check("R9 no vec", vec_load_o, 0);

    // R4/R9: interrupt window of 3791 cycles with enable clear, then lost
    for (int k = 0; k < 3791; k++) begin
      step(k[0], 1, 1, 0, 0);
      if (vec_load_o !== 1'b0) check("R4 masked", vec_load_o, 0);
    end
    step(1, 1, 0, 0, 1);
    check("R9 intr window lost", vec_load_o, 0);
    check("R4 done", vec_load_o, 0);

    // R5: request window passing only non-completing cycles
    for (int k = 0; k < 10; k++) step(0, 1, 1, 0, 1);
    check("R5 no done", vec_load_o, 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule